// File: doc/BRIEF.md
# Cut-Through Output Lane Arbiter

This block is the output-side control for one physical channel of a virtual cut-through switch. Packets have a fixed length and travel on several lanes that share one link. Crossbar inputs offer header flits. The arbiter binds an input to an output lane only when the downstream input buffer for that lane has room for the whole packet. The remaining flits of that packet then stream without any further flow check.

A credit counter is kept for each lane. It starts at the downstream buffer depth. It loses a full packet length at the moment of grant and gains one for each returned credit pulse. Requesters are served in order of how long they have waited. Among the lanes that have room, lanes whose downstream buffer is not reported blocked come first.

Each lane owns a one-flit output register. Every cycle, a free-running pseudo-random sequence picks which occupied lane drives the link. Because that choice is made from the random sequence rather than from the data, it stays off the flit path.

Top module: `vct_out_arb`

## Requirements
- R1: A header offered by an idle input to an idle channel is granted in the same cycle (the arbitration cycle). The input is popped in the next cycle (the transfer cycle), and the header appears on the link one cycle after that.
- R2: Once a lane is granted, it stays bound to its input until PKT_LEN flits have been popped. When that lane is the only active one, those flits leave on consecutive cycles, and `link_tail` is high only on the PKT_LEN-th flit.
- R3: A lane is granted only when its credit count is at least PKT_LEN and the lane is unbound. The grant subtracts PKT_LEN. Each `cred_ret` pulse adds one. A lane never sends more flits than have been reserved for it.
- R4: Among unbound lanes with room, a lane whose `dn_blocked` bit is low is preferred, with ties going to the lowest index. A blocked lane that has room is still granted when no unblocked lane qualifies.
- R5: Among requesting inputs, the one that has waited longest is granted, with ties going to the lowest index. At most one grant is issued per cycle.
- R6: Each cycle, the link carries a flit from one lane that holds a flit. The choice is made from a pseudo-random sequence, so packets on different lanes interleave on the link.
- R7: Every packet arrives on a single lane, contiguously and in order, from a single input. `in_pop` is raised only for an input that is bound and valid, and no input is bound to two lanes at once.
- R8: After reset, `link_valid`, `gnt` and `in_pop` are low, and every lane's credit count equals DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | N_IN | Input i has a flit at its head |
| in_flit | input | N_IN*FLIT_W | Head flit of each input, input i at bits [i*FLIT_W +: FLIT_W] |
| in_pop | output | N_IN | Input i's head flit is taken this cycle |
| gnt | output | N_IN | One-hot grant issued in the arbitration cycle |
| gnt_lane | output | LANE_W | Lane assigned by the current grant |
| dn_blocked | input | N_LANE | Downstream buffer of lane l reports blocked |
| cred_ret | input | N_LANE | One downstream flit slot of lane l was freed |
| link_valid | output | 1 | Link carries a flit this cycle |
| link_lane | output | LANE_W | Lane of the flit on the link |
| link_flit | output | FLIT_W | Flit on the link |
| link_tail | output | 1 | Flit on the link is the last of its packet |

## Verification
The interesting overlap is a grant to a fresh input landing in the same cycle as the link sending, and the output register refilling, for another lane's packet in mid-stream. A second overlap is a credit return arriving in the cycle of a grant on the same lane. Both are provoked by a random phase in which several inputs keep packets queued while credit returns and blocked flags change at random. The directed cases pin down header latency, lane preference, the room threshold and first-come order. Every link flit is judged against a bench credit ledger and a per-lane contiguity tracker built from the requirements alone.

// File: rtl/vct_arb_pkg.sv
package vct_arb_pkg;

    localparam int LFSR_W = 16;
    localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

    typedef enum logic {
        LANE_FREE = 1'b0,
        LANE_OPEN = 1'b1
    } lane_state_e;

    typedef struct packed {
        logic valid;
        logic tail;
    } held_tag_t;

    // Fibonacci shift with taps 16,14,13,11 (maximal length)
    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

endpackage

// File: rtl/vct_req_arb.sv
module vct_req_arb #(
    parameter int N_IN    = 4,
    parameter int N_LANE  = 2,
    parameter int PKT_LEN = 6,
    parameter int CRED_W  = 4,
    parameter int AGE_W   = 8,
    localparam int IN_W   = (N_IN > 1) ? $clog2(N_IN) : 1,
    localparam int LANE_W = (N_LANE > 1) ? $clog2(N_LANE) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [N_IN-1:0]          req,
    input  logic [N_LANE-1:0]        lane_open,
    input  logic [N_LANE*CRED_W-1:0] lane_cred,
    input  logic [N_LANE-1:0]        dn_blocked,
    output logic [N_IN-1:0]          gnt,
    output logic                     gnt_any,
    output logic [IN_W-1:0]          gnt_src,
    output logic [LANE_W-1:0]        gnt_lane
);

    localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

    logic [AGE_W-1:0]  age [N_IN];
    logic [AGE_W-1:0]  best;
    logic              found;
    logic [N_LANE-1:0] space, clear, pool;

    always_comb begin
        found   = 1'b0;
        best    = '0;
        gnt_src = '0;
        for (int i = 0; i < N_IN; i++) begin
            if (req[i] && (!found || age[i] > best)) begin
                found   = 1'b1;
                best    = age[i];
                gnt_src = IN_W'(i);
            end
        end
        for (int l = 0; l < N_LANE; l++) begin
            space[l] = !lane_open[l] &&
                       (lane_cred[l*CRED_W +: CRED_W] >= CRED_W'(PKT_LEN));
        end
        clear    = space & ~dn_blocked;
        pool     = (|clear) ? clear : space;
        gnt_lane = '0;
        for (int l = N_LANE - 1; l >= 0; l--) begin
            if (pool[l]) gnt_lane = LANE_W'(l);
        end
        gnt_any = found && (|pool);
        gnt     = gnt_any ? (N_IN'(1) << gnt_src) : '0;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < N_IN; i++) begin
            if (rst) begin
                age[i] <= '0;
            end else if (req[i] && !gnt[i]) begin
                age[i] <= (age[i] == AGE_MAX) ? age[i] : age[i] + AGE_W'(1);
            end else begin
                age[i] <= '0;
            end
        end
    end

    AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
        gnt_any |-> req[gnt_src]) else $error("grant without request"); // R5

endmodule

// File: rtl/vct_lane_slot.sv
module vct_lane_slot
    import vct_arb_pkg::*;
#(
    parameter int N_IN    = 4,
    parameter int FLIT_W  = 16,
    parameter int PKT_LEN = 6,
    parameter int DEPTH   = 12,
    parameter int CRED_W  = 4,
    localparam int IN_W   = (N_IN > 1) ? $clog2(N_IN) : 1,
    localparam int CNT_W  = (PKT_LEN > 1) ? $clog2(PKT_LEN) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   grant,
    input  logic [IN_W-1:0]        grant_src,
    input  logic [N_IN-1:0]        in_valid,
    input  logic [N_IN*FLIT_W-1:0] in_flit,
    input  logic                   send,
    input  logic                   cred_ret,
    output logic                   lane_open,
    output logic [IN_W-1:0]        lane_src,
    output logic [CRED_W-1:0]      cred,
    output logic [N_IN-1:0]        pop,
    output logic                   held,
    output logic                   held_tail,
    output logic [FLIT_W-1:0]      held_flit
);

    lane_state_e      st;
    logic [CNT_W-1:0] cnt;
    held_tag_t        tag;
    logic             take, last;

    assign take      = (st == LANE_OPEN) && in_valid[lane_src] && (!tag.valid || send);
    assign last      = (cnt == CNT_W'(PKT_LEN - 1));
    assign pop       = take ? (N_IN'(1) << lane_src) : '0;
    assign lane_open = (st == LANE_OPEN);
    assign held      = tag.valid;
    assign held_tail = tag.tail;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= LANE_FREE;
            lane_src  <= '0;
            cnt       <= '0;
            tag       <= '0;
            held_flit <= '0;
            cred      <= CRED_W'(DEPTH);
        end else begin
            cred <= cred + CRED_W'(cred_ret) - (grant ? CRED_W'(PKT_LEN) : CRED_W'(0));
            if (grant) begin
                st       <= LANE_OPEN;
                lane_src <= grant_src;
                cnt      <= '0;
            end else if (take) begin
                cnt <= last ? '0 : cnt + CNT_W'(1);
                if (last) st <= LANE_FREE;
            end
            if (take) begin
                tag.valid <= 1'b1;
                tag.tail  <= last;
                held_flit <= in_flit[lane_src*FLIT_W +: FLIT_W];
            end else if (send) begin
                tag.valid <= 1'b0;
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        cred <= CRED_W'(DEPTH)) else $error("credit above depth"); // R3
    AST_GRANT_SPACE: assert property (@(posedge clk) disable iff (rst)
        grant |-> (st == LANE_FREE && cred >= CRED_W'(PKT_LEN))) else $error("grant without room"); // R3
    AST_SEND_HELD: assert property (@(posedge clk) disable iff (rst)
        send |-> tag.valid) else $error("empty lane sent"); // R6
    AST_OPEN_COUNT: assert property (@(posedge clk) disable iff (rst)
        (st == LANE_OPEN) |-> (cnt < CNT_W'(PKT_LEN))) else $error("flit count overrun"); // R2

endmodule

// File: rtl/vct_link_mux.sv
module vct_link_mux
    import vct_arb_pkg::*;
#(
    parameter int N_LANE  = 2,
    parameter int FLIT_W  = 16,
    localparam int LANE_W = (N_LANE > 1) ? $clog2(N_LANE) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [N_LANE-1:0]        held,
    input  logic [N_LANE-1:0]        held_tail,
    input  logic [N_LANE*FLIT_W-1:0] held_flit,
    output logic [N_LANE-1:0]        send,
    output logic                     link_valid,
    output logic [LANE_W-1:0]        link_lane,
    output logic                     link_tail,
    output logic [FLIT_W-1:0]        link_flit
);

    logic [LFSR_W-1:0] lfsr;
    int                start;
    int                idx;
    logic              found;

    always_ff @(posedge clk) begin
        if (rst) lfsr <= LFSR_SEED;
        else     lfsr <= lfsr_step(lfsr);
    end

    always_comb begin
        start     = int'(lfsr[7:0]) % N_LANE;
        found     = 1'b0;
        link_lane = '0;
        for (int k = 0; k < N_LANE; k++) begin
            idx = (start + k) % N_LANE;
            if (!found && held[idx]) begin
                found     = 1'b1;
                link_lane = LANE_W'(idx);
            end
        end
        link_valid = found;
        send       = found ? (N_LANE'(1) << link_lane) : '0;
        link_flit  = held_flit[link_lane*FLIT_W +: FLIT_W];
        link_tail  = found && held_tail[link_lane];
    end

endmodule

// File: rtl/vct_out_arb.sv
module vct_out_arb
    import vct_arb_pkg::*;
#(
    parameter int N_IN    = 4,
    parameter int N_LANE  = 2,
    parameter int FLIT_W  = 16,
    parameter int PKT_LEN = 6,
    parameter int DEPTH   = 12,
    parameter int AGE_W   = 8,
    localparam int IN_W   = (N_IN > 1) ? $clog2(N_IN) : 1,
    localparam int LANE_W = (N_LANE > 1) ? $clog2(N_LANE) : 1,
    localparam int CRED_W = $clog2(DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [N_IN-1:0]        in_valid,
    input  logic [N_IN*FLIT_W-1:0] in_flit,
    output logic [N_IN-1:0]        in_pop,
    output logic [N_IN-1:0]        gnt,
    output logic [LANE_W-1:0]      gnt_lane,
    input  logic [N_LANE-1:0]      dn_blocked,
    input  logic [N_LANE-1:0]      cred_ret,
    output logic                   link_valid,
    output logic [LANE_W-1:0]      link_lane,
    output logic [FLIT_W-1:0]      link_flit,
    output logic                   link_tail
);

    logic [N_LANE-1:0]        lane_open, held, held_tail, send;
    logic [IN_W-1:0]          lane_src [N_LANE];
    logic [N_IN-1:0]          lane_pop [N_LANE];
    logic [N_LANE*CRED_W-1:0] cred_flat;
    logic [N_LANE*FLIT_W-1:0] held_flat;
    logic [N_IN-1:0]          in_busy, req;
    logic                     gnt_any;
    logic [IN_W-1:0]          gnt_src;

    always_comb begin
        in_busy = '0;
        in_pop  = '0;
        for (int l = 0; l < N_LANE; l++) begin
            if (lane_open[l]) in_busy[lane_src[l]] = 1'b1;
            in_pop = in_pop | lane_pop[l];
        end
    end

    assign req = in_valid & ~in_busy;

    vct_req_arb #(
        .N_IN(N_IN), .N_LANE(N_LANE), .PKT_LEN(PKT_LEN),
        .CRED_W(CRED_W), .AGE_W(AGE_W)
    ) u_arb (
        .clk(clk), .rst(rst), .req(req), .lane_open(lane_open),
        .lane_cred(cred_flat), .dn_blocked(dn_blocked), .gnt(gnt),
        .gnt_any(gnt_any), .gnt_src(gnt_src), .gnt_lane(gnt_lane)
    );

    for (genvar l = 0; l < N_LANE; l++) begin : g_lane
        vct_lane_slot #(
            .N_IN(N_IN), .FLIT_W(FLIT_W), .PKT_LEN(PKT_LEN),
            .DEPTH(DEPTH), .CRED_W(CRED_W)
        ) u_slot (
            .clk(clk), .rst(rst),
            .grant(gnt_any && (gnt_lane == LANE_W'(l))),
            .grant_src(gnt_src), .in_valid(in_valid), .in_flit(in_flit),
            .send(send[l]), .cred_ret(cred_ret[l]),
            .lane_open(lane_open[l]), .lane_src(lane_src[l]),
            .cred(cred_flat[l*CRED_W +: CRED_W]), .pop(lane_pop[l]),
            .held(held[l]), .held_tail(held_tail[l]),
            .held_flit(held_flat[l*FLIT_W +: FLIT_W])
        );
    end

    vct_link_mux #(.N_LANE(N_LANE), .FLIT_W(FLIT_W)) u_mux (
        .clk(clk), .rst(rst), .held(held), .held_tail(held_tail),
        .held_flit(held_flat), .send(send), .link_valid(link_valid),
        .link_lane(link_lane), .link_tail(link_tail), .link_flit(link_flit)
    );

    for (genvar i = 0; i < N_IN; i++) begin : g_own
        logic [N_LANE-1:0] owner;
        always_comb begin
            for (int l = 0; l < N_LANE; l++)
                owner[l] = lane_open[l] && (lane_src[l] == IN_W'(i));
        end
        AST_ONE_OWNER: assert property (@(posedge clk) disable iff (rst)
            $onehot0(owner)) else $error("input bound twice"); // R7
        AST_POP_VALID: assert property (@(posedge clk) disable iff (rst)
            in_pop[i] |-> in_valid[i]) else $error("pop of empty input"); // R7
    end

endmodule

// File: tb/vct_out_arb_test.sv
module vct_out_arb_test;

    localparam int N_IN = 4, N_LANE = 2, FLIT_W = 16, PKT_LEN = 6, DEPTH = 12;

    logic clk = 1'b0, rst = 1'b1;
    always #2 clk = ~clk;

    logic [N_IN-1:0]        in_valid, in_pop, gnt;
    logic [N_IN*FLIT_W-1:0] in_flit;
    logic [0:0]             gnt_lane, link_lane;
    logic [N_LANE-1:0]      dn_blocked = '0, cred_ret = '0;
    logic                   link_valid, link_tail;
    logic [FLIT_W-1:0]      link_flit;

    vct_out_arb uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_flit(in_flit),
        .in_pop(in_pop), .gnt(gnt), .gnt_lane(gnt_lane),
        .dn_blocked(dn_blocked), .cred_ret(cred_ret), .link_valid(link_valid),
        .link_lane(link_lane), .link_flit(link_flit), .link_tail(link_tail)
    );

    int checks = 0, errors = 0;
    int quota[N_IN], seq[N_IN], fidx[N_IN], issued[N_IN], tails[N_IN], exp_seq[N_IN];
    int occ[N_LANE], bfree[N_LANE], resv[N_LANE], cur_src[N_LANE], exp_idx[N_LANE];
    logic [N_IN-1:0] pop_seen = '0;
    bit ret_en = 1'b1, saw_mix = 1'b0;
    int gnt_count = 0, first_src = -1, prev_lane = 0;

    for (genvar i = 0; i < N_IN; i++) begin : g_drv
        assign in_valid[i] = quota[i] > 0;
        assign in_flit[i*FLIT_W +: FLIT_W] = {2'(i), 11'(seq[i]), 3'(fidx[i])};
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // monitor: away from the active edge
    always @(negedge clk) if (!rst) begin
        pop_seen = in_pop;
        for (int i = 0; i < N_IN; i++)
            if (in_pop[i]) chk(in_valid[i], "R7", "pop of empty input", 0, 1);
        for (int l = 0; l < N_LANE; l++) if (cred_ret[l]) bfree[l]++;
        if (|gnt) begin
            for (int i = 0; i < N_IN; i++) if (gnt[i] && first_src < 0) first_src = i;
            gnt_count++;
            chk(bfree[gnt_lane] >= PKT_LEN, "R3", "grant without room", bfree[gnt_lane], PKT_LEN);
            bfree[gnt_lane] -= PKT_LEN;
            resv[gnt_lane] += PKT_LEN;
        end
        if (link_valid) begin
            int l, s, q, x;
            l = link_lane; s = link_flit[15:14]; q = link_flit[13:3]; x = link_flit[2:0];
            chk(resv[l] > 0, "R3", "flit without reservation", resv[l], 1);
            resv[l]--;
            occ[l]++;
            if (exp_idx[l] == 0) cur_src[l] = s;
            chk(x == exp_idx[l] && s == cur_src[l], "R7", "contiguous flit index", x, exp_idx[l]);
            chk(link_tail == (x == PKT_LEN - 1), "R2", "tail marker", link_tail, x == PKT_LEN - 1);
            if (prev_lane != l && exp_idx[prev_lane] != 0) saw_mix = 1'b1;
            prev_lane = l;
            if (link_tail) begin
                chk(q == (exp_seq[s] & 11'h7ff), "R7", "packet order per input", q, exp_seq[s]);
                exp_seq[s]++;
                tails[s]++;
                exp_idx[l] = 0;
            end else begin
                exp_idx[l]++;
            end
        end
    end

    // driver: just after the active edge
    always @(posedge clk) begin
        #1;
        for (int i = 0; i < N_IN; i++) if (pop_seen[i]) begin
            if (fidx[i] == PKT_LEN - 1) begin
                fidx[i] = 0; seq[i]++; quota[i]--;
            end else fidx[i]++;
        end
        pop_seen = '0;
        for (int l = 0; l < N_LANE; l++) begin
            cred_ret[l] = ret_en && occ[l] > 0 && ($urandom % 2 == 1);
            if (cred_ret[l]) occ[l]--;
        end
    end

    task automatic add_pkt(input int i, input int n);
        quota[i] += n; issued[i] += n;
    endtask

    task automatic wait_idle();
        int quiet = 0;
        while (quiet < 30) begin
            @(negedge clk);
            quiet = (quota.sum() == 0 && !link_valid && occ.sum() == 0) ? quiet + 1 : 0;
        end
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        void'($urandom(32'd7));
        for (int i = 0; i < N_IN; i++) begin
            quota[i] = 0; seq[i] = 0; fidx[i] = 0; issued[i] = 0; tails[i] = 0; exp_seq[i] = 0;
        end
        for (int l = 0; l < N_LANE; l++) begin
            occ[l] = 0; bfree[l] = DEPTH; resv[l] = 0; cur_src[l] = 0; exp_idx[l] = 0;
        end
        repeat (3) @(negedge clk);
        chk(!link_valid && gnt == 0 && in_pop == 0, "R8", "reset outputs quiet", link_valid, 0);
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        chk(!link_valid && gnt == 0, "R8", "idle after reset", link_valid, 0);

        // R1/R2 directed latency
        @(posedge clk); #1 add_pkt(1, 1);
        @(negedge clk);
        chk(gnt == 4'b0010 && gnt_lane == 0, "R1", "grant in arbitration cycle", gnt, 2);
        @(negedge clk);
        chk(in_pop == 4'b0010 && !link_valid, "R1", "pop in transfer cycle", in_pop, 2);
        for (int k = 0; k < PKT_LEN; k++) begin
            @(negedge clk);
            chk(link_valid && link_flit[2:0] == k && link_flit[15:14] == 1, "R2", "back-to-back flit", link_flit[2:0], k);
        end
        @(negedge clk);
        chk(!link_valid, "R2", "link idle after tail", link_valid, 0);
        wait_idle();

        // R4 lane preference
        @(posedge clk); #1 dn_blocked = 2'b01; add_pkt(0, 1);
        @(negedge clk);
        chk(gnt == 4'b0001 && gnt_lane == 1, "R4", "unblocked lane preferred", gnt_lane, 1);
        @(posedge clk); #1 add_pkt(1, 1);
        @(negedge clk);
        chk(gnt == 4'b0010 && gnt_lane == 0, "R4", "blocked lane with room used", gnt_lane, 0);
        wait_idle();
        dn_blocked = 2'b00;

        // R3 room threshold: returns off, two packets per lane fit
        ret_en = 1'b0; gnt_count = 0;
        @(posedge clk); #1 add_pkt(0, 5);
        repeat (80) @(negedge clk);
        chk(gnt_count == 4, "R3", "grants without credit return", gnt_count, 4);
        chk(quota[0] == 1 && in_pop == 0, "R3", "fifth packet held back", quota[0], 1);
        @(posedge clk); #1 ret_en = 1'b1;
        wait_idle();
        chk(gnt_count == 5, "R3", "grant after credits return", gnt_count, 5);

        // R5 first-come order
        ret_en = 1'b0;
        @(posedge clk); #1 add_pkt(0, 4);
        while (quota[0] != 0 || link_valid) @(negedge clk);
        @(posedge clk); #1 add_pkt(2, 1);
        @(posedge clk); #1 add_pkt(0, 1);
        repeat (3) @(posedge clk);
        #1 first_src = -1; ret_en = 1'b1;
        wait_idle();
        chk(first_src == 2, "R5", "oldest request served first", first_src, 2);

        // random phase
        for (int c = 0; c < 4000; c++) begin
            @(posedge clk); #1;
            for (int i = 0; i < N_IN; i++)
                if (quota[i] < 3 && $urandom % 8 == 0) add_pkt(i, 1);
            if (c % 8 == 0) dn_blocked = 2'($urandom);
        end
        dn_blocked = '0;
        wait_idle();
        for (int i = 0; i < N_IN; i++)
            chk(tails[i] == issued[i], "R7", "all packets delivered", tails[i], issued[i]);
        chk(saw_mix, "R6", "lanes interleave on link", saw_mix, 1);
        finish_run();
    end

endmodule